// File: doc/BRIEF.md
# Translation Unit Control Registers with Cache Invalidation

This block is the 32-bit register file that software uses to set up an address translation unit. Each stream has a configuration word, whose translation-enable bit is sent to the table walker. Each stream also has four table base words, which go to the walker unchanged. A stream-select mask and a cache operation register drive invalidation of the translation cache.

Software first writes the mask and then writes the invalidate command. It then polls a busy flag until the flag reads 0. The command bit clears itself. The block copies the mask at the moment the command is accepted and holds a request to the cache, with that copy, until the cache acknowledges. Busy drops in the cycle after the acknowledge. A second command issued while one is pending has no effect.

Top module: `xlat_ctrl_regs`

## Requirements
- R1: After reset, every configuration and table base word reads 0, the mask register reads 0x0000FFFF, the busy flag reads 0, and no invalidate request is driven.
- R2: The configuration word of stream s is at byte offset 0x100 + 4*s. It reads back as written, and its bit 7 drives `xlat_en[s]` from the cycle after the write.
- R3: Table base word i (0..3) of stream s is at offset 0x200 + 16*s + 4*i. It reads back as written and appears unchanged in `tbl_base` slice (s*4 + i).
- R4: The mask register is at offset 0x34. It stores bits [15:0] of the write data, one bit per stream, and its bits [31:16] read 0.
- R5: When no invalidate is pending, a write to offset 0x20 with bit 20 set raises `flush_req` in the next cycle. `flush_sid_mask` then equals the mask register value at the time of the write, and bit 2 of offset 0x20 reads 1.
- R6: `flush_req` and `flush_sid_mask` stay constant until a cycle in which `flush_ack` is high. In the cycle after that acknowledge, both `flush_req` and the busy bit are 0.
- R7: A command write while an invalidate is pending is ignored. A mask write while an invalidate is pending updates the register but leaves `flush_sid_mask` unchanged.
- R8: Bit 20 of offset 0x20 always reads 0, as do all its bits other than bit 2. A write to 0x20 with bit 20 clear starts nothing.
- R9: Reads of offsets that are unmapped or not word-aligned return 0. Writes to such offsets change no register.
- R10: Read data is registered: `reg_rdata` shows the value addressed in the cycle `reg_rd` was high, one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| xlat_en | output | 16 | Per-stream translation enable |
| tbl_base | output | 2048 | All table base words, stream-major |
| flush_req | output | 1 | Invalidate request to the translation cache |
| flush_sid_mask | output | 16 | Streams to invalidate, held with the request |
| flush_ack | input | 1 | Invalidate acknowledge from the cache |

## Verification
The assertions check several properties on every cycle. A pending request holds with a stable mask until it is acknowledged. The request drops right after the acknowledge and never starts without a command. An accepted command copies the current mask. A configuration write with bit 7 set turns on that stream's enable. Unmapped reads and command-register reads return zero in the places required. Only the bench scenarios can show the rest: full readback of every stream's words, the address map, the busy flag seen through polling, command writes ignored while busy, and writes to unmapped offsets leaving the mapped registers untouched.

// File: rtl/xlat_regs_pkg.sv
package xlat_regs_pkg;
  localparam int DW          = 32;
  localparam int OFF_OP      = 'h020;
  localparam int OFF_MASK    = 'h034;
  localparam int OFF_CFG     = 'h100;
  localparam int OFF_BASE    = 'h200;
  localparam int CMD_BIT     = 20;
  localparam int BUSY_BIT    = 2;
  localparam int EN_BIT      = 7;
  localparam int BASE_PER_SID = 4;

  typedef struct packed {
    logic op;
    logic mask;
    logic cfg;
    logic base;
  } hit_t;
endpackage

// File: rtl/xlat_addr_decode.sv
module xlat_addr_decode
  import xlat_regs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NS     = 16,
  localparam int SID_W = $clog2(NS),
  localparam int IDX_W = $clog2(BASE_PER_SID)
) (
  input  logic [ADDR_W-1:0] addr,
  output hit_t              hit,
  output logic              any_hit,
  output logic [SID_W-1:0]  sid,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] CFG_LO  = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] CFG_HI  = ADDR_W'(OFF_CFG + 4*NS);
  localparam logic [ADDR_W-1:0] BASE_LO = ADDR_W'(OFF_BASE);
  localparam logic [ADDR_W-1:0] BASE_HI = ADDR_W'(OFF_BASE + 4*BASE_PER_SID*NS);

  logic              aligned;
  logic [ADDR_W-1:0] cfg_rel, base_rel;

  always_comb begin
    aligned  = (addr[1:0] == 2'b00);
    cfg_rel  = addr - CFG_LO;
    base_rel = addr - BASE_LO;
    hit.op   = aligned && (addr == ADDR_W'(OFF_OP));
    hit.mask = aligned && (addr == ADDR_W'(OFF_MASK));
    hit.cfg  = aligned && (addr >= CFG_LO) && (addr < CFG_HI);
    hit.base = aligned && (addr >= BASE_LO) && (addr < BASE_HI);
    any_hit  = |hit;
    idx      = IDX_W'(addr >> 2);
    sid      = hit.cfg ? SID_W'(cfg_rel >> 2) : SID_W'(base_rel >> (2 + IDX_W));
  end
endmodule

// File: rtl/xlat_stream_regs.sv
module xlat_stream_regs
  import xlat_regs_pkg::*;
#(
  parameter int NS     = 16,
  localparam int NB    = BASE_PER_SID,
  localparam int SID_W = $clog2(NS),
  localparam int IDX_W = $clog2(NB)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic                 base_we,
  input  logic [SID_W-1:0]     sid,
  input  logic [IDX_W-1:0]     idx,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rd_cfg,
  output logic [DW-1:0]        rd_base,
  output logic [NS-1:0]        xlat_en,
  output logic [NS*NB*DW-1:0]  base_flat
);
  logic [DW-1:0] cfg_q  [NS];
  logic [DW-1:0] base_q [NS*NB];

  for (genvar s = 0; s < NS; s++) begin : g_sid
    always_ff @(posedge clk) begin
      if (rst) cfg_q[s] <= '0;
      else if (cfg_we && sid == SID_W'(s)) cfg_q[s] <= wdata;
    end
    assign xlat_en[s] = cfg_q[s][EN_BIT];

    // a configuration write with the enable bit set turns the stream on
    assert_en_follows_R2: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && sid == SID_W'(s) && wdata[EN_BIT]) |=> xlat_en[s]);

    for (genvar i = 0; i < NB; i++) begin : g_idx
      always_ff @(posedge clk) begin
        if (rst) base_q[s*NB+i] <= '0;
        else if (base_we && sid == SID_W'(s) && idx == IDX_W'(i)) base_q[s*NB+i] <= wdata;
      end
      assign base_flat[(s*NB+i)*DW +: DW] = base_q[s*NB+i];
    end
  end

  assign rd_cfg  = cfg_q[sid];
  assign rd_base = base_q[{sid, idx}];
endmodule

// File: rtl/xlat_flush_ctrl.sv
module xlat_flush_ctrl #(
  parameter int NS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mask_we,
  input  logic [NS-1:0] mask_wdata,
  input  logic          cmd,
  input  logic          ack,
  output logic [NS-1:0] mask_q,
  output logic          req,
  output logic [NS-1:0] req_mask
);
  always_ff @(posedge clk) begin
    if (rst) mask_q <= '1;
    else if (mask_we) mask_q <= mask_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req      <= 1'b0;
      req_mask <= '0;
    end else if (req) begin
      if (ack) req <= 1'b0;
    end else if (cmd) begin
      req      <= 1'b1;
      req_mask <= mask_q;
    end
  end

  assert_start_R5: assert property (@(posedge clk) disable iff (rst)
    (!req && cmd) |=> (req && req_mask == $past(mask_q)));
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> (req && $stable(req_mask)));
  assert_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (req && ack) |=> !req);
  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (rst)
    (!req && !cmd) |=> !req);
endmodule

// File: rtl/xlat_ctrl_regs.sv
module xlat_ctrl_regs
  import xlat_regs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NS     = 16,
  localparam int NB    = BASE_PER_SID,
  localparam int SID_W = $clog2(NS),
  localparam int IDX_W = $clog2(NB)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  output logic [NS-1:0]        xlat_en,
  output logic [NS*NB*DW-1:0]  tbl_base,
  output logic                 flush_req,
  output logic [NS-1:0]        flush_sid_mask,
  input  logic                 flush_ack
);
  hit_t             hit;
  logic             any_hit;
  logic [SID_W-1:0] sid;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    rd_cfg, rd_base, rd_mux;
  logic [NS-1:0]    mask_q;

  xlat_addr_decode #(.ADDR_W(ADDR_W), .NS(NS)) u_dec (
    .addr(reg_addr), .hit(hit), .any_hit(any_hit), .sid(sid), .idx(idx)
  );

  xlat_stream_regs #(.NS(NS)) u_streams (
    .clk(clk), .rst(rst),
    .cfg_we(reg_wr && hit.cfg), .base_we(reg_wr && hit.base),
    .sid(sid), .idx(idx), .wdata(reg_wdata),
    .rd_cfg(rd_cfg), .rd_base(rd_base),
    .xlat_en(xlat_en), .base_flat(tbl_base)
  );

  xlat_flush_ctrl #(.NS(NS)) u_flush (
    .clk(clk), .rst(rst),
    .mask_we(reg_wr && hit.mask), .mask_wdata(reg_wdata[NS-1:0]),
    .cmd(reg_wr && hit.op && reg_wdata[CMD_BIT]), .ack(flush_ack),
    .mask_q(mask_q), .req(flush_req), .req_mask(flush_sid_mask)
  );

  always_comb begin
    rd_mux = '0;
    if (hit.op)        rd_mux[BUSY_BIT] = flush_req;
    else if (hit.mask) rd_mux = DW'(mask_q);
    else if (hit.cfg)  rd_mux = rd_cfg;
    else if (hit.base) rd_mux = rd_base;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !any_hit) |=> reg_rdata == '0);
  assert_cmd_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && hit.op) |=> !reg_rdata[CMD_BIT]);
endmodule

// File: tb/tb_xlat_ctrl_regs.sv
module tb_xlat_ctrl_regs;
  localparam int NS = 16;
  localparam int NB = 4;

  logic clk = 0, rst = 1;
  logic reg_wr = 0, reg_rd = 0, flush_ack = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NS-1:0] xlat_en, flush_sid_mask;
  logic [NS*NB*32-1:0] tbl_base;
  logic flush_req;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  xlat_ctrl_regs dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xlat_en(xlat_en), .tbl_base(tbl_base),
    .flush_req(flush_req), .flush_sid_mask(flush_sid_mask), .flush_ack(flush_ack)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  function automatic logic [31:0] cfg_pat(int s);
    return 32'h5A00_0000 ^ (32'(s) * 32'h0101_0013);
  endfunction
  function automatic logic [31:0] base_pat(int k);
    return ((k % 3 == 0) ? 32'h8000_0000 : 32'h0) | (32'(k) * 32'h0003_1415 + 32'h11);
  endfunction

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 req", 32'(flush_req), 0);
    check("R1 xlat_en", 32'(xlat_en), 0);
    rd(12'h034, d); check("R1 mask", d, 32'h0000_FFFF);
    rd(12'h020, d); check("R1 busy", d, 0);
    for (int s = 0; s < NS; s++) begin
      rd(12'(32'h100 + 4*s), d); check("R1 cfg", d, 0);
      for (int i = 0; i < NB; i++) begin
        rd(12'(32'h200 + 16*s + 4*i), d); check("R1 base", d, 0);
      end
    end
    // R2 configuration words and enables
    for (int s = 0; s < NS; s++) wr(12'(32'h100 + 4*s), cfg_pat(s));
    for (int s = 0; s < NS; s++) begin
      logic [31:0] p;
      p = cfg_pat(s);
      rd(12'(32'h100 + 4*s), d); check("R2 cfg readback", d, p);
      check("R2 xlat_en", 32'(xlat_en[s]), 32'(p[7]));
    end
    wr(12'h10C, 32'h0000_0080);
    check("R2 enable one cycle after write", 32'(xlat_en[3]), 1);
    wr(12'h10C, 32'h0000_0000);
    check("R2 disable", 32'(xlat_en[3]), 0);
    // R3 table base words
    for (int k = 0; k < NS*NB; k++) wr(12'(32'h200 + 4*k), base_pat(k));
    for (int k = 0; k < NS*NB; k++) begin
      rd(12'(32'h200 + 4*k), d); check("R3 base readback", d, base_pat(k));
      check("R3 base output", tbl_base[k*32 +: 32], base_pat(k));
    end
    // R4 mask width
    wr(12'h034, 32'hDEAD_00A5); rd(12'h034, d); check("R4 mask", d, 32'h0000_00A5);
    // R8 write without command bit
    wr(12'h020, 32'hFFEF_FFFF);
    check("R8 no start", 32'(flush_req), 0);
    rd(12'h020, d); check("R8 op reads zero", d, 0);
    // R5/R6/R7 invalidate handshakes with several ack delays
    for (int dly = 0; dly < 4; dly++) begin
      logic [15:0] m;
      m = 16'h00A5 ^ 16'(dly * 16'h1230);
      wr(12'h034, 32'(m));
      wr(12'h020, 32'h0010_0000);
      check("R5 req", 32'(flush_req), 1);
      check("R5 mask captured", 32'(flush_sid_mask), 32'(m));
      rd(12'h020, d); check("R5 busy and R8 cmd bit reads 0", d, 32'h4);
      wr(12'h034, 32'h0000_1111);
      check("R7 mask write while busy", 32'(flush_sid_mask), 32'(m));
      wr(12'h020, 32'h0010_0000);
      check("R7 cmd while busy", 32'(flush_sid_mask), 32'(m));
      for (int w = 0; w < dly; w++) begin
        @(negedge clk);
        check("R6 held", 32'(flush_req), 1);
        check("R6 mask stable", 32'(flush_sid_mask), 32'(m));
      end
      @(negedge clk); flush_ack = 1;
      @(negedge clk); flush_ack = 0;
      check("R6 req dropped", 32'(flush_req), 0);
      rd(12'h020, d); check("R6 busy cleared", d, 0);
      rd(12'h034, d); check("R7 mask register updated", d, 32'h0000_1111);
    end
    // R7 command accepted again after completion
    wr(12'h020, 32'h0010_0000);
    check("R7 new cmd after idle", 32'(flush_req), 1);
    check("R7 new mask", 32'(flush_sid_mask), 32'h1111);
    @(negedge clk); flush_ack = 1; @(negedge clk); flush_ack = 0;
    // R9 unmapped and misaligned offsets
    begin
      logic [11:0] un [12] = '{12'h000, 12'h004, 12'h024, 12'h030, 12'h038, 12'h0FC,
                               12'h140, 12'h1FC, 12'h300, 12'hFFC, 12'h101, 12'h202};
      for (int u = 0; u < 12; u++) begin
        wr(un[u], 32'hFFFF_FFFF);
        rd(un[u], d); check("R9 unmapped read", d, 0);
      end
    end
    check("R9 no flush from unmapped", 32'(flush_req), 0);
    rd(12'h100, d); check("R9 cfg untouched", d, cfg_pat(0));
    rd(12'h200, d); check("R9 base untouched", d, base_pat(0));
    rd(12'h034, d); check("R9 mask untouched", d, 32'h1111);
    // R10 read latency and hold
    @(negedge clk); reg_rd = 1; reg_addr = 12'h104;
    @(negedge clk); reg_rd = 0; reg_addr = 12'h034;
    check("R10 registered read", reg_rdata, cfg_pat(1));
    @(negedge clk);
    check("R10 hold without read", reg_rdata, cfg_pat(1));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule